// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block arbitrates between seven interrupt sources and presents the winner to a processor core as a vector address. Each source gets a 2-bit priority level. One bit comes from a high-priority register and one from a low-priority register, so there are four levels. When the high register is left at zero, its reset value, only levels 0 and 1 are reachable and the controller acts as a plain two-level system. Among the sources at the same level, a fixed natural order decides. External interrupt 0 ranks first, then timer 0, external interrupt 1, timer 1, UART0, timer 2 and UART1.

The controller keeps one in-service bit per level so that it can follow nested handlers. A new request is offered only if its level is strictly above the highest level now in service. When the core acknowledges the offered vector, the bit for that level is set. A return-from-interrupt clears the highest in-service bit. The global enable and the per-source enables gate every request before arbitration.

Top module: `ipc_four_level`

## Requirements
- R1: The level of source i is the 2-bit code {prio_hi[i], prio_lo[i]}, so level 3 is the highest and level 0 the lowest.
- R2: No request is offered (int_pend stays 0) while glb_en is 0 or the requesting source's src_en bit is 0.
- R3: Among the eligible sources, the one with the highest level is offered, whatever its index.
- R4: Among eligible sources at the same level, the lowest index wins. The indices are 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 UART0, 5 timer2, 6 UART1.
- R5: The vector of source index i is 8'h03 + 8*i, giving 03h, 0Bh, 13h, 1Bh, 23h, 2Bh and 33h. int_lvl carries the winner's level.
- R6: After reset, int_pend is 0, int_vec and int_lvl are 0, and inserv is 0.
- R7: A source is eligible only when its level is strictly greater than the highest set bit of inserv. An equal or lower level is held off.
- R8: int_ack while int_pend is 1 sets inserv bit int_lvl. int_ack while int_pend is 0 has no effect.
- R9: reti clears the highest set bit of inserv and has no effect when inserv is 0. If reti and a valid int_ack arrive in the same cycle, the clear is applied first and the set second.
- R10: int_pend, int_vec and int_lvl are registered. They reflect the inputs of the previous cycle, judged against the in-service state that results from that same cycle's int_ack and reti.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 7 | Request lines, index order as in R4 |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 7 | Per-source enables |
| prio_lo | input | 7 | Low bit of each source's level |
| prio_hi | input | 7 | High bit of each source's level |
| int_ack | input | 1 | Core takes the offered vector |
| reti | input | 1 | Return from the current handler |
| int_pend | output | 1 | A vector is offered |
| int_vec | output | 8 | Vector address of the offered source |
| int_lvl | output | 2 | Level of the offered source |
| inserv | output | 4 | In-service bit per level |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. This applies to the offered vector, its level and the in-service mask. An acknowledge or return applied in a cycle has already taken effect in the offer that appears after the following edge. The driver applies one stimulus per cycle at the falling edge and pushes the predicted result, which its own model computes. The monitor pops each prediction a quarter period after the next rising edge, so every comparison lands in the single cycle the result belongs to.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int NUM_SRC = 7;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int VEC_W   = 8;
  localparam logic [VEC_W-1:0] VEC_BASE   = 8'h03;
  localparam logic [VEC_W-1:0] VEC_STRIDE = 8'h08;

  typedef logic [LVL_W-1:0] lvl_t;

  // vector address from source index
  function automatic logic [VEC_W-1:0] vector_of(input int unsigned idx);
    return VEC_BASE + VEC_STRIDE * VEC_W'(idx);
  endfunction

  // clear the most significant set bit of an in-service mask
  function automatic logic [NUM_LVL-1:0] drop_top(input logic [NUM_LVL-1:0] m);
    logic [NUM_LVL-1:0] r;
    logic               done;
    r    = m;
    done = 1'b0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (!done && m[l]) begin
        r[l] = 1'b0;
        done = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ipc_level_map.sv
module ipc_level_map #(
  parameter int N_SRC = ipc_pkg::NUM_SRC
) (
  input  logic [N_SRC-1:0]           lo_bits,
  input  logic [N_SRC-1:0]           hi_bits,
  output ipc_pkg::lvl_t [N_SRC-1:0]  src_lvl
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_map
    assign src_lvl[g] = {hi_bits[g], lo_bits[g]};
  end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
  parameter int N_SRC = ipc_pkg::NUM_SRC,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]              req,
  input  logic [N_SRC-1:0]              en,
  input  logic                          glb_en,
  input  ipc_pkg::lvl_t [N_SRC-1:0]     src_lvl,
  input  logic [ipc_pkg::NUM_LVL-1:0]   busy_mask,
  output logic [N_SRC-1:0]              eligible,
  output logic                          win_vld,
  output logic [IDX_W-1:0]              win_idx,
  output ipc_pkg::lvl_t                 win_lvl
);
  // a source qualifies when no level at or above its own is in service
  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign eligible[g] = req[g] & en[g] & glb_en &
                         ((busy_mask >> src_lvl[g]) == '0);
  end

  // scan from the last index down; >= lets lower indices win ties
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (!win_vld || src_lvl[i] >= win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = src_lvl[i];
      end
    end
  end
endmodule

// File: rtl/ipc_inservice.sv
module ipc_inservice (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_en,
  input  ipc_pkg::lvl_t                set_lvl,
  input  logic                         clr_en,
  output logic [ipc_pkg::NUM_LVL-1:0]  busy_q,
  output logic [ipc_pkg::NUM_LVL-1:0]  busy_nx
);
  localparam int NL = ipc_pkg::NUM_LVL;

  logic [NL-1:0] after_clr;

  always_comb begin
    after_clr = clr_en ? ipc_pkg::drop_top(busy_q) : busy_q;
    busy_nx   = after_clr | (set_en ? (NL'(1) << set_lvl) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_nx;
  end
endmodule

// File: rtl/ipc_four_level.sv
module ipc_four_level #(
  parameter int N_SRC = ipc_pkg::NUM_SRC,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int VW    = ipc_pkg::VEC_W,
  localparam int LW    = ipc_pkg::LVL_W,
  localparam int NL    = ipc_pkg::NUM_LVL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             glb_en,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] prio_lo,
  input  logic [N_SRC-1:0] prio_hi,
  input  logic             int_ack,
  input  logic             reti,
  output logic             int_pend,
  output logic [VW-1:0]    int_vec,
  output logic [LW-1:0]    int_lvl,
  output logic [NL-1:0]    inserv
);
  ipc_pkg::lvl_t [N_SRC-1:0] src_lvl;
  logic [N_SRC-1:0]          eligible;
  logic                      win_vld;
  logic [IDX_W-1:0]          win_idx;
  ipc_pkg::lvl_t             win_lvl;
  logic [NL-1:0]             busy_q, busy_nx;

  // named events for the checker
  logic ack_take;
  logic reti_take;

  assign ack_take  = int_ack & int_pend;
  assign reti_take = reti & (|busy_q);

  ipc_level_map #(.N_SRC(N_SRC)) u_map (
    .lo_bits (prio_lo),
    .hi_bits (prio_hi),
    .src_lvl (src_lvl)
  );

  ipc_inservice u_isr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (ack_take),
    .set_lvl (int_lvl),
    .clr_en  (reti),
    .busy_q  (busy_q),
    .busy_nx (busy_nx)
  );

  // arbitration sees the mask as it will be after this edge
  ipc_arbiter #(.N_SRC(N_SRC)) u_arb (
    .req       (irq_req),
    .en        (src_en),
    .glb_en    (glb_en),
    .src_lvl   (src_lvl),
    .busy_mask (busy_nx),
    .eligible  (eligible),
    .win_vld   (win_vld),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_pend <= 1'b0;
      int_vec  <= '0;
      int_lvl  <= '0;
    end else begin
      int_pend <= win_vld;
      int_vec  <= win_vld ? ipc_pkg::vector_of(32'(win_idx)) : '0;
      int_lvl  <= win_vld ? win_lvl : '0;
    end
  end

  assign inserv = busy_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       glb_en,
  input logic       reti,
  input logic       int_pend,
  input logic [7:0] int_vec,
  input logic [1:0] int_lvl,
  input logic [3:0] inserv,
  input logic       ack_take,
  input logic       reti_take
);
  // R2
  pend_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend |-> $past(glb_en));

  // R5
  vector_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend |-> (int_vec[2:0] == 3'b011 && int_vec <= 8'h33));

  // R7
  strictly_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend |-> ((inserv >> int_lvl) == 4'b0000));

  // R8
  ack_marks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> inserv[$past(int_lvl)]);

  // R8
  idle_mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_take && !reti) |=> $stable(inserv));

  // R9
  reti_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_take && !ack_take) |=> ($countones(inserv) == $countones($past(inserv)) - 1));
endmodule

bind ipc_four_level ipc_checker u_ipc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .reti      (reti),
  .int_pend  (int_pend),
  .int_vec   (int_vec),
  .int_lvl   (int_lvl),
  .inserv    (inserv),
  .ack_take  (ack_take),
  .reti_take (reti_take)
);

// File: tb/test_ipc_four_level.sv
module test_ipc_four_level;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_req = '0, src_en = '0, prio_lo = '0, prio_hi = '0;
  logic       glb_en = 1'b0, int_ack = 1'b0, reti = 1'b0;
  logic       int_pend;
  logic [7:0] int_vec;
  logic [1:0] int_lvl;
  logic [3:0] inserv;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic       pend;
    logic [7:0] vec;
    logic [1:0] lvl;
    logic [3:0] ins;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  // bench model state
  logic       m_pend = 1'b0;
  logic [1:0] m_lvl  = '0;
  logic [3:0] m_ins  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_four_level i_ipc_four_level (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .glb_en(glb_en),
    .src_en(src_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
    .int_ack(int_ack), .reti(reti), .int_pend(int_pend),
    .int_vec(int_vec), .int_lvl(int_lvl), .inserv(inserv)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and predict the result
  task automatic step(input logic [6:0] rq, input logic [6:0] en,
                      input logic [6:0] lo, input logic [6:0] hi,
                      input logic g, input logic a, input logic r,
                      input string tag);
    exp_t e;
    int   top_busy;
    int   best;
    int   best_lv;
    @(negedge clk);
    irq_req = rq; src_en = en; prio_lo = lo; prio_hi = hi;
    glb_en = g; int_ack = a; reti = r;
    if (r) begin
      for (int l = 3; l >= 0; l--) begin
        if (m_ins[l]) begin m_ins[l] = 1'b0; break; end
      end
    end
    if (a && m_pend) m_ins[m_lvl] = 1'b1;
    top_busy = -1;
    for (int l = 0; l < 4; l++) if (m_ins[l]) top_busy = l;
    best = -1; best_lv = -1;
    for (int i = 0; i < 7; i++) begin
      int lv;
      lv = 2 * int'(hi[i]) + int'(lo[i]);
      if (rq[i] && en[i] && g && lv > top_busy && lv > best_lv) begin
        best = i; best_lv = lv;
      end
    end
    m_pend = (best >= 0);
    m_lvl  = m_pend ? 2'(best_lv) : 2'd0;
    e.pend = m_pend;
    e.vec  = m_pend ? (8'h03 | 8'(best << 3)) : 8'h00;
    e.lvl  = m_lvl;
    e.ins  = m_ins;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare a quarter period after the edge that produced the result
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "pend (R10)", int'(int_pend), int'(e.pend));
        if (e.pend) begin
          check(e.tag, "vec", int'(int_vec), int'(e.vec));
          check(e.tag, "lvl", int'(int_lvl), int'(e.lvl));
        end
        check(e.tag, "inserv", int'(inserv), int'(e.ins));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: state held in reset
    check("R6", "pend", int'(int_pend), 0);
    check("R6", "vec", int'(int_vec), 0);
    check("R6", "inserv", int'(inserv), 0);
    rst_n = 1'b1;

    // R2: gating
    step(7'h7F, 7'h7F, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, "R2");
    step(7'h7F, 7'h00, 7'h00, 7'h00, 1'b1, 1'b0, 1'b0, "R2");
    step(7'h7F, 7'h08, 7'h00, 7'h00, 1'b1, 1'b0, 1'b0, "R2");
    step(7'h01, 7'h7E, 7'h00, 7'h00, 1'b1, 1'b0, 1'b0, "R2");

    // R4 R5: natural order at equal level, every vector
    for (int k = 0; k < 7; k++)
      step(7'(7'h7F << k), 7'h7F, 7'h00, 7'h00, 1'b1, 1'b0, 1'b0, "R4 R5");

    // R1 R3: levels from the two registers
    step(7'h7F, 7'h7F, 7'h40, 7'h00, 1'b1, 1'b0, 1'b0, "R1 R3");
    step(7'h7F, 7'h7F, 7'h40, 7'h20, 1'b1, 1'b0, 1'b0, "R1 R3");
    step(7'h7F, 7'h7F, 7'h50, 7'h30, 1'b1, 1'b0, 1'b0, "R1 R3");
    step(7'h60, 7'h7F, 7'h40, 7'h40, 1'b1, 1'b0, 1'b0, "R1 R4");

    // R8 R7: nesting
    step(7'h04, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b0, 1'b0, "R10");
    step(7'h04, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b1, 1'b0, "R8");
    step(7'h05, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b0, 1'b0, "R7");
    step(7'h01, 7'h7F, 7'h01, 7'h00, 1'b1, 1'b0, 1'b0, "R7");
    step(7'h01, 7'h7F, 7'h01, 7'h00, 1'b1, 1'b1, 1'b0, "R8");
    step(7'h03, 7'h7F, 7'h01, 7'h00, 1'b1, 1'b0, 1'b0, "R7");
    step(7'h03, 7'h7F, 7'h01, 7'h02, 1'b1, 1'b0, 1'b0, "R7");

    // R9: simultaneous return and acknowledge, then unwinding
    step(7'h02, 7'h7F, 7'h01, 7'h02, 1'b1, 1'b1, 1'b1, "R9");
    step(7'h02, 7'h7F, 7'h01, 7'h02, 1'b1, 1'b0, 1'b1, "R9 R7");
    step(7'h00, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b0, 1'b1, "R9");
    step(7'h00, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b0, 1'b1, "R9");
    step(7'h00, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b0, 1'b1, "R9");

    // R8: acknowledge with nothing offered
    step(7'h00, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b1, 1'b0, "R8");
    step(7'h10, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b1, 1'b0, "R8");
    step(7'h10, 7'h7F, 7'h00, 7'h00, 1'b1, 1'b1, 1'b0, "R8");
    step(7'h00, 7'h00, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, "R2");

    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule